// File: doc/BRIEF.md
# Fast Data Transfer Handshake Unit

This unit lets a debug probe move blocks of data between itself and the processor at low cost per word. When the processor loads from or stores to a small window of the probe-mapped memory segment, it stalls. The access is held pending inside the unit. The probe completes the access by scanning a single register. That register is a one-bit handshake flag with a data word behind it.

Each scan does two things at once. It reports whether completion will succeed, and it requests completion. At capture, the flag position is loaded with the success condition: an access is pending and its address lies in the 16-byte window. For a store, the data field is loaded with the stored word. At update, a zero shifted into the flag requests completion. If the captured condition was true, the unit ends the stall. For a load, it also hands the shifted-in word to the processor.

A pending access outside the window is never completed here. It is left for the ordinary processor-access path.

Top module: `fastdata_xfer`

## Requirements
- R1: After reset, `pend_o`, `done_o` and `tdo_o` are 0.
- R2: `req_i` with no access pending latches direction, address and store data, and `pend_o` reads 1 from the next cycle. It then stays 1 until a completion. A `req_i` while an access is pending is ignored.
- R3: A capture loads the flag position with 1 only when an access is pending and its address is in the window. Otherwise it loads 0. The flag is the first bit seen on `tdo_o` after capture.
- R4: The window is byte addresses 0xFF200000 through 0xFF20000F inclusive. 0xFF1FFFFF and 0xFF200010 lie outside it.
- R5: A capture loads the data field with the store data for a store (`wr_i`=1) and with zero for a load (`wr_i`=0). Each shift moves the chain one place toward `tdo_o`. The flag goes out first, then data bits 0 to 31. Shifted-in bits enter at the far end in the same order.
- R6: An update whose shifted-in flag is 0, after a capture that saw success, drives `done_o` high for exactly one cycle in the cycle after the update. `pend_o` is 0 in that same cycle.
- R7: An update whose shifted-in flag is 1 completes nothing, and the access stays pending.
- R8: For a completed load, `rdata_o` equals the 32-bit word shifted in, valid from the `done_o` cycle. A completed store leaves `rdata_o` unchanged.
- R9: A pending access outside the window is never completed by any scan.
- R10: Each update consumes the captured success condition. An update with no capture since the previous update completes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor starts an access to the probe segment |
| wr_i | input | 1 | 1 = store (upload), 0 = load (download) |
| addr_i | input | 32 | Byte address of the access |
| wdata_i | input | 32 | Store data |
| pend_o | output | 1 | Access pending, processor stalled |
| done_o | output | 1 | One-cycle access-complete strobe |
| rdata_o | output | 32 | Load data returned to the processor |
| capture_i | input | 1 | Scan capture strobe |
| shift_i | input | 1 | Scan shift strobe |
| update_i | input | 1 | Scan update strobe |
| tdi_i | input | 1 | Scan serial input |
| tdo_o | output | 1 | Scan serial output |

## Verification
The bench builds the unit with its default parameters: a 32-bit data word, 32-bit addresses, and a 16-byte window at 0xFF200000. With these values the tests can reach both window edges (0xFF200000 and 0xFF20000F) and the addresses just outside them, as well as full 33-bit scans that carry distinct data patterns. It checks the handshake outcomes one by one: a flag of 1, an update with no capture, an attempt with nothing pending, and a repeated request.

// File: rtl/fdx_pkg.sv
package fdx_pkg;
  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_dir_e;
endpackage

// File: rtl/fdx_win_dec.sv
module fdx_win_dec #(
  parameter int unsigned         ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]   WIN_BASE  = 32'hFF20_0000,
  parameter int unsigned         WIN_BYTES = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned LOW_W = (WIN_BYTES > 1) ? $clog2(WIN_BYTES) : 0;

  generate
    if (LOW_W == 0) begin : g_exact
      assign hit_o = (addr_i == WIN_BASE);
    end else begin : g_aligned
      assign hit_o = (addr_i[ADDR_W-1:LOW_W] == WIN_BASE[ADDR_W-1:LOW_W]);
    end
  endgenerate
endmodule

// File: rtl/fdx_pend_ctl.sv
module fdx_pend_ctl
  import fdx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fire_i,
  output logic              pend_o,
  output acc_dir_e          dir_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              done_o
);
  logic pend_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      dir_o   <= ACC_LOAD;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      done_q <= fire_i;
      if (pend_q) begin
        if (fire_i) pend_q <= 1'b0;
      end else if (req_i) begin
        pend_q  <= 1'b1;
        dir_o   <= wr_i ? ACC_STORE : ACC_LOAD;
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
    end
  end

  assign pend_o = pend_q;
  assign done_o = done_q;

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_q) && !done_q) |-> pend_q);                      // R2
  AST_REQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_q) && pend_q) |-> $stable(addr_o) && $stable(wdata_o)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);                                         // R6
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !pend_q);                                         // R6
endmodule

// File: rtl/fdx_scan_reg.sv
module fdx_scan_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              tdi_i,
  input  logic              cap_flag_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic              tdo_o,
  output logic              flag_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned CHAIN_W = DATA_W + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else if (capture_i) begin
      chain_q <= {cap_data_i, cap_flag_i};
    end else if (shift_i) begin
      chain_q <= {tdi_i, chain_q[CHAIN_W-1:1]};
    end
  end

  assign tdo_o  = chain_q[0];
  assign flag_o = chain_q[0];
  assign data_o = chain_q[CHAIN_W-1:1];

  AST_CAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(capture_i) |-> (tdo_o == $past(cap_flag_i)));          // R3
  AST_SHIFT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(shift_i) && !$past(capture_i)) |-> (tdo_o == $past(chain_q[1]))); // R5
endmodule

// File: rtl/fastdata_xfer.sv
module fastdata_xfer
  import fdx_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'hFF20_0000,
  parameter int unsigned       WIN_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pend_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  output logic              tdo_o
);
  logic              pend;
  acc_dir_e          dir;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic              win_hit, ok_now, ok_cap_q, fire;
  logic              sc_flag;
  logic [DATA_W-1:0] sc_data, cap_data;
  logic [DATA_W-1:0] rdata_q;

  fdx_pend_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .fire_i  (fire),
    .pend_o  (pend),
    .dir_o   (dir),
    .addr_o  (acc_addr),
    .wdata_o (acc_wdata),
    .done_o  (done_o)
  );

  fdx_win_dec #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_win (
    .addr_i (acc_addr),
    .hit_o  (win_hit)
  );

  assign ok_now   = pend & win_hit;
  assign cap_data = (dir == ACC_STORE) ? acc_wdata : '0;

  fdx_scan_reg #(.DATA_W(DATA_W)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture_i),
    .shift_i    (shift_i),
    .tdi_i      (tdi_i),
    .cap_flag_i (ok_now),
    .cap_data_i (cap_data),
    .tdo_o      (tdo_o),
    .flag_o     (sc_flag),
    .data_o     (sc_data)
  );

  // success seen at capture is consumed by the next update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ok_cap_q <= 1'b0;
    else if (capture_i) ok_cap_q <= ok_now;
    else if (update_i)  ok_cap_q <= 1'b0;
  end

  assign fire = update_i & ~sc_flag & ok_cap_q & pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rdata_q <= '0;
    else if (fire && (dir == ACC_LOAD))  rdata_q <= sc_data;
  end

  assign pend_o  = pend;
  assign rdata_o = rdata_q;

  AST_CTRL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({capture_i, shift_i, update_i}));                   // R5
  AST_DONE_AFTER_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(update_i) && !$past(tdo_o));                // R6
  AST_DONE_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> win_hit);                                         // R9
  AST_RDATA_STORE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dir == ACC_STORE) |-> $stable(rdata_o));          // R8
endmodule

// File: tb/fastdata_xfer_tb_top.sv
module fastdata_xfer_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, wr_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic        pend_o, done_o, tdo_o;
  logic [31:0] rdata_o;
  logic        capture_i = 1'b0, shift_i = 1'b0, update_i = 1'b0, tdi_i = 1'b0;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  fastdata_xfer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .pend_o(pend_o), .done_o(done_o), .rdata_o(rdata_o),
    .capture_i(capture_i), .shift_i(shift_i), .update_i(update_i),
    .tdi_i(tdi_i), .tdo_o(tdo_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic do_req(input logic wr, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; wr_i = wr; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  // capture, 33 shifts, update; returns bits seen and done/pend after update
  task automatic scan(input logic flag_in, input logic [31:0] din,
                      output logic flag_out, output logic [31:0] dout,
                      output logic done_seen, output logic pend_after,
                      output logic done_next);
    logic [32:0] tx, rx;
    tx = {din, flag_in};
    @(negedge clk);
    capture_i = 1'b1;
    @(negedge clk);
    capture_i = 1'b0;
    for (int i = 0; i < 33; i++) begin
      rx[i] = tdo_o;
      shift_i = 1'b1; tdi_i = tx[i];
      @(negedge clk);
    end
    shift_i = 1'b0;
    update_i = 1'b1;
    @(negedge clk);
    update_i = 1'b0;
    done_seen  = done_o;
    pend_after = pend_o;
    @(negedge clk);
    done_next = done_o;
    flag_out = rx[0];
    dout     = rx[32:1];
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pend", {31'd0, pend_o}, 32'd0);
    chk("R1 done", {31'd0, done_o}, 32'd0);
    chk("R1 tdo",  {31'd0, tdo_o},  32'd0);
  endtask

  task automatic t_load();
    logic f, d, p, dn; logic [31:0] o;
    do_reset();
    do_req(1'b0, 32'hFF20_0004, 32'h0);
    chk("R2 pend set", {31'd0, pend_o}, 32'd1);
    scan(1'b0, 32'hA5A5_1234, f, o, d, p, dn);
    chk("R3 flag ok", {31'd0, f}, 32'd1);
    chk("R5 load data zero", o, 32'h0);
    chk("R6 done", {31'd0, d}, 32'd1);
    chk("R6 pend clr", {31'd0, p}, 32'd0);
    chk("R6 one cycle", {31'd0, dn}, 32'd0);
    chk("R8 rdata", rdata_o, 32'hA5A5_1234);
  endtask

  task automatic t_store();
    logic f, d, p, dn; logic [31:0] o;
    do_req(1'b1, 32'hFF20_000C, 32'hDEAD_BEEF);
    do_req(1'b1, 32'hFF20_0000, 32'h1111_2222);  // ignored while pending
    scan(1'b0, 32'h0, f, o, d, p, dn);
    chk("R5 upload data", o, 32'hDEAD_BEEF);
    chk("R2 second req ignored", o, 32'hDEAD_BEEF);
    chk("R6 store done", {31'd0, d}, 32'd1);
    chk("R8 rdata kept", rdata_o, 32'hA5A5_1234);
  endtask

  task automatic t_flag_one();
    logic f, d, p, dn; logic [31:0] o;
    do_reset();
    do_req(1'b0, 32'hFF20_0000, 32'h0);
    scan(1'b1, 32'h1234_5678, f, o, d, p, dn);
    chk("R7 no done", {31'd0, d}, 32'd0);
    chk("R7 still pend", {31'd0, p}, 32'd1);
    // R10: zeros shifted, update with no capture
    for (int i = 0; i < 33; i++) begin
      shift_i = 1'b1; tdi_i = 1'b0;
      @(negedge clk);
    end
    shift_i = 1'b0; update_i = 1'b1;
    @(negedge clk);
    update_i = 1'b0;
    chk("R10 no done w/o capture", {31'd0, done_o}, 32'd0);
    chk("R10 still pend", {31'd0, pend_o}, 32'd1);
    scan(1'b0, 32'h0BAD_F00D, f, o, d, p, dn);
    chk("R4 low edge ok", {31'd0, f}, 32'd1);
    chk("R8 rdata", rdata_o, 32'h0BAD_F00D);
  endtask

  task automatic t_window(input logic [31:0] a, input logic exp_ok, input string tag);
    logic f, d, p, dn; logic [31:0] o;
    do_reset();
    do_req(1'b0, a, 32'h0);
    scan(1'b0, 32'hCAFE_0001, f, o, d, p, dn);
    chk({tag, " flag"}, {31'd0, f}, {31'd0, exp_ok});
    chk({tag, " done"}, {31'd0, d}, {31'd0, exp_ok});
    chk({"R9 ", tag, " pend"}, {31'd0, p}, {31'd0, ~exp_ok});
  endtask

  task automatic t_idle();
    logic f, d, p, dn; logic [31:0] o;
    do_reset();
    scan(1'b0, 32'h5555_AAAA, f, o, d, p, dn);
    chk("R3 idle flag", {31'd0, f}, 32'd0);
    chk("R3 idle done", {31'd0, d}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_store();
    t_flag_one();
    t_window(32'hFF20_000F, 1'b1, "R4 high edge");
    t_window(32'hFF20_0010, 1'b0, "R4 above");
    t_window(32'hFF1F_FFFF, 1'b0, "R4 below");
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule